// File: doc/BRIEF.md
# DRAM Rank Power-Down Idle Controller

This block decides when the ranks of one memory channel may drop clock-enable and enter power-down. Per-rank command-activity strobes feed idle counters. When a rank has been idle for a programmed number of cycles and the selected mode permits power-down for that rank's bank state, the block raises a CKE-low request for the rank. A command to the rank removes the request in the same cycle. The block also reports whether each power-down is an active one (a bank open) or a precharge one (all banks closed), and whether the DLL may be turned off.

A 32-bit configuration word holds three fields. The idle threshold sits in bits 7:0, the mode code in bits 11:8 and the scope select in bit 12. When the scope bit is set, one shared counter governs the whole channel and every rank enters power-down together. A lock input freezes the word.

Top module: `rank_pdn_ctrl`

## Requirements
- R1: After reset the configuration word reads 0 and no CKE-low, DLL-off or active flag is asserted, however long the ranks stay idle.
- R2: A write with cfg_wr_en high and cfg_lock low loads bits 12:0 on the next clock edge. Bits 31:13 always read as zero.
- R3: While cfg_lock is high, writes are ignored and the read value holds.
- R4: In per-rank scope (bit 12 = 0), each rank has its own counter. Rank r requests power-down once its counter has recorded at least the threshold (bits 7:0) of consecutive idle cycles. That is, the request is high in the idle cycle after the threshold-th consecutive idle clock edge.
- R5: A cycle with rank_cmd[r] high drops cke_low_req[r] in that same cycle and restarts that rank's count from zero.
- R6: A threshold of 0 never produces a request.
- R7: Mode bits 11:8 decide which power-down is allowed. A rank with an open bank may enter only for codes 1, 3 or 7. A rank with all banks closed may enter only for codes 2, 3, 6 or 7.
- R8: Codes 0, 4, 5 and 8 to 15 never produce a request.
- R9: In global scope (bit 12 = 1), a shared counter advances only on cycles with no command to any rank and clears on any command. All requests are then either all high or all low. They are high only if the mode allows every rank's bank state.
- R10: dll_off_req[r] is high exactly when cke_low_req[r] is high, rank r has all banks closed, and the mode is 6 or 7.
- R11: pdn_active[r] is high exactly when cke_low_req[r] is high and rank r has an open bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_lock | input | 1 | Blocks configuration writes while high |
| cfg_rdata | output | 32 | Current configuration word |
| rank_cmd | input | NUM_RANKS | A command targets the rank this cycle |
| rank_bank_open | input | NUM_RANKS | The rank has at least one open bank |
| cke_low_req | output | NUM_RANKS | Request to drop CKE for the rank |
| dll_off_req | output | NUM_RANKS | DLL may be turned off for the rank |
| pdn_active | output | NUM_RANKS | Requested power-down is an active one |

## Verification
The embedded properties check the following on every cycle:
- reserved bits read zero;
- the lock holds the word;
- a commanded rank or a disabling threshold or mode never shows a request;
- a request follows an idle cycle;
- global scope keeps requests all-or-none;
- the DLL-off and active flags are consistent with the requests.

Only the bench scenarios can show that a request appears after exactly the threshold count and not one cycle early. They also show that each mode code selects the right ranks for a given bank pattern, and that a command on one rank delays only that rank in per-rank scope but delays the whole channel in global scope.

// File: rtl/rank_pdn_ctrl.sv
module rank_pdn_ctrl #(
  parameter int NUM_RANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [31:0]          cfg_wdata,
  input  logic                 cfg_lock,
  output logic [31:0]          cfg_rdata,
  input  logic [NUM_RANKS-1:0] rank_cmd,
  input  logic [NUM_RANKS-1:0] rank_bank_open,
  output logic [NUM_RANKS-1:0] cke_low_req,
  output logic [NUM_RANKS-1:0] dll_off_req,
  output logic [NUM_RANKS-1:0] pdn_active
);
  localparam int THR_W  = 8;
  localparam int MODE_W = 4;
  localparam int CFG_W  = THR_W + MODE_W + 1;

  logic [CFG_W-1:0] cfg_q;
  logic [THR_W-1:0] thr;
  logic [MODE_W-1:0] mode;
  logic glob;

  assign thr  = cfg_q[THR_W-1:0];
  assign mode = cfg_q[THR_W +: MODE_W];
  assign glob = cfg_q[CFG_W-1];
  assign cfg_rdata = {{(32-CFG_W){1'b0}}, cfg_q};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       cfg_q <= '0;
    else if (cfg_wr_en && !cfg_lock)  cfg_q <= cfg_wdata[CFG_W-1:0];

  logic apd_en, ppd_en, dll_mode, thr_ok;
  assign apd_en   = (mode == 4'd1) || (mode == 4'd3) || (mode == 4'd7);
  assign ppd_en   = (mode == 4'd2) || (mode == 4'd3) || (mode == 4'd6) || (mode == 4'd7);
  assign dll_mode = (mode == 4'd6) || (mode == 4'd7);
  assign thr_ok   = (thr != '0);

  logic [THR_W-1:0] g_cnt;
  logic g_ok, g_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          g_cnt <= '0;
    else if (|rank_cmd)  g_cnt <= '0;
    else if (g_cnt < thr) g_cnt <= g_cnt + 1'b1;

  assign g_ok  = (!(|rank_bank_open) || apd_en) && ((&rank_bank_open) || ppd_en);
  assign g_req = thr_ok && g_ok && !(|rank_cmd) && (g_cnt >= thr);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [THR_W-1:0] cnt;
    logic mode_ok, r_req;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           cnt <= '0;
      else if (rank_cmd[r]) cnt <= '0;
      else if (cnt < thr)   cnt <= cnt + 1'b1;

    assign mode_ok = rank_bank_open[r] ? apd_en : ppd_en;
    assign r_req   = thr_ok && mode_ok && !rank_cmd[r] && (cnt >= thr);

    assign cke_low_req[r] = glob ? g_req : r_req;
    assign dll_off_req[r] = cke_low_req[r] && !rank_bank_open[r] && dll_mode;
    assign pdn_active[r]  = cke_low_req[r] && rank_bank_open[r];
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:CFG_W] == '0);
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(cfg_rdata));
  a_r5_cmd_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_low_req & rank_cmd) == '0);
  a_r5_req_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cke_low_req & $past(rank_cmd)) == '0));
  a_r6_zero_thr_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7:0] == 8'd0) |-> (cke_low_req == '0));
  a_r8_reserved_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[11:8] inside {4'd0, 4'd4, 4'd5, [4'd8:4'd15]}) |-> (cke_low_req == '0));
  a_r9_global_together: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[12] |-> ((cke_low_req == '0) || (&cke_low_req)));
  a_r10_dll_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_off_req & ~cke_low_req) == '0);
  a_r11_active_open: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_active & ~rank_bank_open) == '0);
endmodule

// File: tb/rank_pdn_ctrl_tb.sv
module rank_pdn_ctrl_tb;
  localparam int NR = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0, cfg_lock = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NR-1:0] rank_cmd = '0, rank_bank_open = '0;
  logic [NR-1:0] cke_low_req, dll_off_req, pdn_active;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rank_pdn_ctrl #(.NUM_RANKS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_lock(cfg_lock), .cfg_rdata(cfg_rdata), .rank_cmd(rank_cmd),
    .rank_bank_open(rank_bank_open), .cke_low_req(cke_low_req),
    .dll_off_req(dll_off_req), .pdn_active(pdn_active)
  );

  // {glob[20], mode[19:16], open[15:12], req[11:8], dll[7:4], act[3:0]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    24'h0_1_3_3_0_3, // R7 APD: open ranks only
    24'h0_2_3_C_0_0, // R7 PPD: closed ranks only
    24'h0_3_3_F_0_3, // R7 both
    24'h0_6_5_A_A_0, // R7 R10 PPD dll-off
    24'h0_7_5_F_A_5, // R7 R10 R11
    24'h0_0_5_0_0_0, // R8
    24'h0_4_5_0_0_0, // R8
    24'h0_5_5_0_0_0, // R8
    24'h0_8_5_0_0_0, // R8
    24'h0_F_5_0_0_0, // R8
    24'h1_3_3_F_0_3, // R9
    24'h1_1_3_0_0_0, // R9 closed ranks block APD-only
    24'h1_2_0_F_0_0, // R9
    24'h1_7_1_F_E_1, // R9 R10
    24'h1_6_1_0_0_0  // R9 open rank blocks
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] d);
    @(negedge clk); cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic kick_all();
    rank_cmd = '1;
    @(negedge clk); rank_cmd = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg", cfg_rdata, 32'h0);
    idle(20);
    check("R1 req", {28'h0, cke_low_req}, 32'h0);
    check("R1 dll", {28'h0, dll_off_req | pdn_active}, 32'h0);

    write_cfg(32'hFFFF_FFFF);
    check("R2 readback", cfg_rdata, 32'h0000_1FFF);
    write_cfg(32'h0000_0305);
    check("R2 fields", cfg_rdata, 32'h0000_0305);

    cfg_lock = 1'b1;
    write_cfg(32'h0000_1234);
    check("R3 lock", cfg_rdata, 32'h0000_0305);
    cfg_lock = 1'b0;

    for (int v = 0; v < NV; v++) begin
      write_cfg({19'h0, VEC[v][20], VEC[v][19:16], 8'd3});
      rank_bank_open = VEC[v][15:12];
      kick_all();
      idle(2);
      check("R4 early", {28'h0, cke_low_req}, 32'h0);
      idle(1);
      check("R7 R8 R9 req", {28'h0, cke_low_req}, {28'h0, VEC[v][11:8]});
      check("R10 dll", {28'h0, dll_off_req}, {28'h0, VEC[v][7:4]});
      check("R11 act", {28'h0, pdn_active}, {28'h0, VEC[v][3:0]});
    end

    // R6 zero threshold
    write_cfg(32'h0000_0300);
    rank_bank_open = 4'b0011;
    kick_all(); idle(20);
    check("R6 zero thr", {28'h0, cke_low_req}, 32'h0);

    // R4/R5 per-rank independence
    write_cfg(32'h0000_0304);
    kick_all(); idle(2);
    rank_cmd = 4'b0010;
    @(negedge clk); rank_cmd = '0;
    @(negedge clk);
    check("R4 per-rank", {28'h0, cke_low_req}, 32'h0000_000D);
    idle(2);
    check("R4 rank1 early", {28'h0, cke_low_req}, 32'h0000_000D);
    idle(1);
    check("R4 rank1 late", {28'h0, cke_low_req}, 32'h0000_000F);
    rank_cmd = 4'b0001; #1;
    check("R5 same cycle", {28'h0, cke_low_req}, 32'h0000_000E);
    @(negedge clk); rank_cmd = '0; #1;
    check("R5 restart", {28'h0, cke_low_req}, 32'h0000_000E);

    // R9 global: one command holds all ranks
    write_cfg(32'h0000_1304);
    kick_all(); idle(2);
    rank_cmd = 4'b0010;
    @(negedge clk); rank_cmd = '0;
    @(negedge clk);
    check("R9 blocked", {28'h0, cke_low_req}, 32'h0);
    idle(2);
    check("R9 early", {28'h0, cke_low_req}, 32'h0);
    idle(1);
    check("R9 together", {28'h0, cke_low_req}, 32'h0000_000F);
    rank_cmd = 4'b0100; #1;
    check("R9 R5 exit", {28'h0, cke_low_req}, 32'h0);
    rank_cmd = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule